// File: doc/BRIEF.md
# ADC Result Register Bank

This block holds the conversion results of an analog-to-digital converter that serves nineteen sample slots. A completion event carries a slot number and a 12-bit raw result; the bank stores the result, marks it valid, and flags an overrun when a result arrives before the previous one was read. The first four slots can be switched into a double-buffer mode. In that mode consecutive results go alternately to two registers, and each register has its own flags.

Four interrupt lines watch the stream of start and completion events. Each line has a slot mask. A per-slot position bit chooses whether the line reacts when the conversion starts or when it completes. Each line also records when its flag is set again while already pending. Software reaches everything through a simple word-addressed read/write port. Reading a result clears its flags, and status flags clear when a 1 is written to them.

Top module: `adc_result_bank`

## Requirements
- R1: A read with `rd_en` high returns on `rdata` one cycle later. Primary result registers are at addresses 0 to 18, one per slot. The word is laid out as: result in bits 15:0, overrun in bit 16, valid in bit 17, zeros above. `rdata` holds its value while `rd_en` is low. Unmapped addresses read 0.
- R2: Bit 0 of the control register (address 24) selects the result format. When 0, the 12-bit raw value is zero-extended. When 1, the MSB of the raw value is inverted and the result is sign-extended to 16 bits, so 0x800 reads 0x0000 and 0x000 reads 0xF800. The format is applied when the word is read.
- R3: A completion event sets the valid flag of the register it lands in. Reading that register's word clears the flag. Completion events with a slot number of 19 or more are ignored.
- R4: A result that lands in a register whose valid flag is still 1 sets that register's overrun flag. A read clears the overrun flag. When a read and a new result hit the same register in the same cycle, the read takes effect first.
- R5: Control bits 8:5 enable double buffering for slots 0 to 3. When enabled, results for the slot go alternately to the primary register and to a second register at address 20+slot, starting with the primary. Each register has its own valid and overrun flags. When disabled, every result goes to the primary register and the alternation restarts.
- R6: The status register (address 30) reports, in bit 9, whether any valid flag is set and, in bit 10, whether any overrun flag is set.
- R7: Line l (0 to 3) has a 19-bit source mask at address 26+l. Its flag (status bit l) is set only by events whose slot has its mask bit set.
- R8: The position register (address 25) holds one bit per slot. When the bit is 1, a start event for that slot sets the flags of the lines that select it. When the bit is 0, a completion event does. The other kind of event has no effect on the flags.
- R9: `irq[l]` is the line's flag gated by control bit 1+l.
- R10: An event that sets a line flag which is already 1 sets that line's overwrite bit (status bit 4+l). Status bit 8 is the OR of the four overwrite bits.
- R11: Writing 1 to status bits 3:0 or 7:4 clears the matching flag or overwrite bit. A set in the same cycle wins over the clear.
- R12: After reset, all flags, results, control, position and mask registers are 0, and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_valid | input | 1 | A conversion is starting |
| start_slot | input | 5 | Slot of the starting conversion |
| done_valid | input | 1 | A conversion has completed |
| done_slot | input | 5 | Slot of the completed conversion |
| done_raw | input | 12 | Raw conversion result |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 5 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| irq | output | 4 | Interrupt requests, one per line |

## Verification
Directed sequences first drive format edge values (0x000, 0x7FF, 0x800) through both formats. They then cover a double-buffered slot across alternation, overrun and mode switch-off, and a single line with its position bit flipped between start and completion. These cases separate errors in the data path, the buffer pointer and the event selection. A long random run then mixes starts, completions (including out-of-range slots), reads of every address and random write-1-to-clear strobes. These collide in the same cycle and stress the read-before-write and set-over-clear orderings. Every read and every cycle's `irq` is compared with a bench model built from the requirements.

// File: rtl/adc_bank_pkg.sv
package adc_bank_pkg;

   typedef enum logic {
      FMT_STRAIGHT = 1'b0,
      FMT_TWOS     = 1'b1
   } res_fmt_e;

endpackage

// File: rtl/adc_slot_store.sv
module adc_slot_store #(
   parameter int RAW_W   = 12,
   parameter bit HAS_SEC = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [RAW_W-1:0] wr_raw,
   input  logic             dbuf_en,
   input  logic             rd_pri,
   input  logic             rd_sec,
   output logic [RAW_W-1:0] pri_raw,
   output logic             pri_vld,
   output logic             pri_ovr,
   output logic [RAW_W-1:0] sec_raw,
   output logic             sec_vld,
   output logic             sec_ovr
);

   logic to_sec;
   logic wr_pri;
   logic pri_keep_v, pri_keep_o;

   assign wr_pri     = wr_en & ~to_sec;
   assign pri_keep_v = pri_vld & ~rd_pri;
   assign pri_keep_o = pri_ovr & ~rd_pri;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pri_raw <= '0;
         pri_vld <= 1'b0;
         pri_ovr <= 1'b0;
      end else if (wr_pri) begin
         pri_raw <= wr_raw;
         pri_vld <= 1'b1;
         pri_ovr <= pri_keep_o | pri_keep_v;
      end else begin
         pri_vld <= pri_keep_v;
         pri_ovr <= pri_keep_o;
      end
   end

   generate
      if (HAS_SEC) begin : g_sec
         logic ptr_q;
         logic wr_sec;
         logic sec_keep_v, sec_keep_o;

         assign to_sec     = dbuf_en & ptr_q;
         assign wr_sec     = wr_en & to_sec;
         assign sec_keep_v = sec_vld & ~rd_sec;
         assign sec_keep_o = sec_ovr & ~rd_sec;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        ptr_q <= 1'b0;
            else if (!dbuf_en) ptr_q <= 1'b0;
            else if (wr_en)    ptr_q <= ~ptr_q;
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sec_raw <= '0;
               sec_vld <= 1'b0;
               sec_ovr <= 1'b0;
            end else if (wr_sec) begin
               sec_raw <= wr_raw;
               sec_vld <= 1'b1;
               sec_ovr <= sec_keep_o | sec_keep_v;
            end else begin
               sec_vld <= sec_keep_v;
               sec_ovr <= sec_keep_o;
            end
         end

         // R5: two results in a row on a double-buffered slot never land in the same register
         a_r5_alternate: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && dbuf_en) |=> (ptr_q != $past(ptr_q) || !dbuf_en));
      end else begin : g_single
         logic unused_sec_in;
         assign unused_sec_in = ^{dbuf_en, rd_sec};
         assign to_sec  = 1'b0;
         assign sec_raw = '0;
         assign sec_vld = 1'b0;
         assign sec_ovr = 1'b0;
      end
   endgenerate

   a_r4_overrun_on_unread: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_pri && pri_vld && !rd_pri) |=> pri_ovr);

   a_r3_read_clears_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_pri && !wr_pri) |=> (!pri_vld && !pri_ovr));

endmodule

// File: rtl/adc_irq_line.sv
module adc_irq_line #(
   parameter int NUM_SLOTS = 19,
   parameter int SLOT_W    = 5
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start_valid,
   input  logic [SLOT_W-1:0]    start_slot,
   input  logic                 done_valid,
   input  logic [SLOT_W-1:0]    done_slot,
   input  logic [NUM_SLOTS-1:0] src_mask,
   input  logic [NUM_SLOTS-1:0] at_start,
   input  logic                 clr_flag,
   input  logic                 clr_ovw,
   input  logic                 line_en,
   output logic                 flag,
   output logic                 ovw,
   output logic                 irq
);

   localparam logic [SLOT_W-1:0] SLOT_LIM = SLOT_W'(NUM_SLOTS);

   logic start_hit, done_hit, hit;

   assign start_hit = start_valid && (start_slot < SLOT_LIM) &&
                      src_mask[start_slot] && at_start[start_slot];
   assign done_hit  = done_valid && (done_slot < SLOT_LIM) &&
                      src_mask[done_slot] && !at_start[done_slot];
   assign hit       = start_hit | done_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag <= 1'b0;
         ovw  <= 1'b0;
      end else begin
         flag <= hit | (flag & ~clr_flag);
         ovw  <= (hit & flag) | (ovw & ~clr_ovw);
      end
   end

   assign irq = flag & line_en;

   a_r10_overwrite_seen: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && flag) |=> ovw);

   a_r11_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> flag);

   a_r9_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag && !hit) |=> !irq);

endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
   parameter int NUM_SLOTS = 19,
   parameter int NUM_DBUF  = 4,
   parameter int NUM_LINES = 4,
   parameter int RAW_W     = 12,
   parameter int RES_W     = 16,
   parameter int ADDR_W    = 5,
   parameter int DATA_W    = 32,
   parameter int SLOT_W    = $clog2(NUM_SLOTS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_valid,
   input  logic [SLOT_W-1:0] start_slot,
   input  logic              done_valid,
   input  logic [SLOT_W-1:0] done_slot,
   input  logic [RAW_W-1:0]  done_raw,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic [NUM_LINES-1:0] irq
);
   import adc_bank_pkg::*;

   localparam int A_SEC_BASE  = NUM_SLOTS + 1;
   localparam int A_CTRL      = A_SEC_BASE + NUM_DBUF;
   localparam int A_POS       = A_CTRL + 1;
   localparam int A_MASK_BASE = A_POS + 1;
   localparam int A_STAT      = A_MASK_BASE + NUM_LINES;
   localparam int CTRL_W      = 1 + NUM_LINES + NUM_DBUF;
   localparam int EN_LSB      = 1;
   localparam int DB_LSB      = 1 + NUM_LINES;
   localparam int STAT_W      = 2 * NUM_LINES + 3;

   generate
      if (RAW_W > RES_W || RES_W + 2 > DATA_W || NUM_DBUF > NUM_SLOTS ||
          A_STAT >= (1 << ADDR_W) || STAT_W > DATA_W || NUM_SLOTS > DATA_W) begin : g_bad_cfg
         $error("adc_result_bank: parameter set does not fit the register map");
      end
   endgenerate

   logic [CTRL_W-1:0]    ctrl_q;
   logic [NUM_SLOTS-1:0] pos_q;
   logic [NUM_SLOTS-1:0] mask_q [NUM_LINES];

   res_fmt_e             fmt;
   logic [NUM_LINES-1:0] line_en;
   logic [NUM_DBUF-1:0]  dbuf_en;

   assign fmt     = res_fmt_e'(ctrl_q[0]);
   assign line_en = ctrl_q[EN_LSB +: NUM_LINES];
   assign dbuf_en = ctrl_q[DB_LSB +: NUM_DBUF];

   // ---------------- configuration registers ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         pos_q  <= '0;
         for (int l = 0; l < NUM_LINES; l++) mask_q[l] <= '0;
      end else if (wr_en) begin
         if (addr == ADDR_W'(A_CTRL)) ctrl_q <= wdata[CTRL_W-1:0];
         if (addr == ADDR_W'(A_POS))  pos_q  <= wdata[NUM_SLOTS-1:0];
         for (int l = 0; l < NUM_LINES; l++)
            if (addr == ADDR_W'(A_MASK_BASE + l)) mask_q[l] <= wdata[NUM_SLOTS-1:0];
      end
   end

   // ---------------- result storage ----------------
   logic [RAW_W-1:0]     pri_raw [NUM_SLOTS];
   logic [NUM_SLOTS-1:0] pri_vld, pri_ovr;
   logic [RAW_W-1:0]     sec_raw [NUM_DBUF];
   logic [NUM_DBUF-1:0]  sec_vld, sec_ovr;

   genvar s;
   generate
      for (s = 0; s < NUM_SLOTS; s++) begin : g_slot
         logic slot_wr, slot_rd;
         assign slot_wr = done_valid && (done_slot == SLOT_W'(s));
         assign slot_rd = rd_en && (addr == ADDR_W'(s));
         if (s < NUM_DBUF) begin : g_dual
            logic sec_rd;
            assign sec_rd = rd_en && (addr == ADDR_W'(A_SEC_BASE + s));
            adc_slot_store #(.RAW_W(RAW_W), .HAS_SEC(1'b1)) u_store (
               .clk     (clk),
               .rst_n   (rst_n),
               .wr_en   (slot_wr),
               .wr_raw  (done_raw),
               .dbuf_en (dbuf_en[s]),
               .rd_pri  (slot_rd),
               .rd_sec  (sec_rd),
               .pri_raw (pri_raw[s]),
               .pri_vld (pri_vld[s]),
               .pri_ovr (pri_ovr[s]),
               .sec_raw (sec_raw[s]),
               .sec_vld (sec_vld[s]),
               .sec_ovr (sec_ovr[s])
            );
         end else begin : g_one
            logic [RAW_W-1:0] unused_raw;
            logic             unused_v, unused_o;
            adc_slot_store #(.RAW_W(RAW_W), .HAS_SEC(1'b0)) u_store (
               .clk     (clk),
               .rst_n   (rst_n),
               .wr_en   (slot_wr),
               .wr_raw  (done_raw),
               .dbuf_en (1'b0),
               .rd_pri  (slot_rd),
               .rd_sec  (1'b0),
               .pri_raw (pri_raw[s]),
               .pri_vld (pri_vld[s]),
               .pri_ovr (pri_ovr[s]),
               .sec_raw (unused_raw),
               .sec_vld (unused_v),
               .sec_ovr (unused_o)
            );
         end
      end
   endgenerate

   // ---------------- interrupt lines ----------------
   logic [NUM_LINES-1:0] flag, ovw, clr_flag, clr_ovw;
   logic                 stat_wr;

   assign stat_wr  = wr_en && (addr == ADDR_W'(A_STAT));
   assign clr_flag = stat_wr ? wdata[NUM_LINES-1:0] : '0;
   assign clr_ovw  = stat_wr ? wdata[NUM_LINES +: NUM_LINES] : '0;

   genvar l;
   generate
      for (l = 0; l < NUM_LINES; l++) begin : g_line
         adc_irq_line #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_line (
            .clk         (clk),
            .rst_n       (rst_n),
            .start_valid (start_valid),
            .start_slot  (start_slot),
            .done_valid  (done_valid),
            .done_slot   (done_slot),
            .src_mask    (mask_q[l]),
            .at_start    (pos_q),
            .clr_flag    (clr_flag[l]),
            .clr_ovw     (clr_ovw[l]),
            .line_en     (line_en[l]),
            .flag        (flag[l]),
            .ovw         (ovw[l]),
            .irq         (irq[l])
         );
      end
   endgenerate

   // ---------------- read path ----------------
   function automatic logic [RES_W-1:0] fmt_result(input logic [RAW_W-1:0] raw, input res_fmt_e f);
      logic [RAW_W-1:0] flipped;
      flipped = {~raw[RAW_W-1], raw[RAW_W-2:0]};
      if (f == FMT_TWOS) return RES_W'($signed(flipped));
      return RES_W'(raw);
   endfunction

   function automatic logic [DATA_W-1:0] data_word(input logic [RAW_W-1:0] raw,
                                                   input logic v, input logic o, input res_fmt_e f);
      return DATA_W'({v, o, fmt_result(raw, f)});
   endfunction

   logic              sum_vld, sum_ovr;
   logic [STAT_W-1:0] stat_word;
   logic [DATA_W-1:0] rd_word;

   assign sum_vld   = (|pri_vld) | (|sec_vld);
   assign sum_ovr   = (|pri_ovr) | (|sec_ovr);
   assign stat_word = {sum_ovr, sum_vld, |ovw, ovw, flag};

   always_comb begin
      rd_word = '0;
      for (int i = 0; i < NUM_SLOTS; i++)
         if (addr == ADDR_W'(i)) rd_word = data_word(pri_raw[i], pri_vld[i], pri_ovr[i], fmt);
      for (int i = 0; i < NUM_DBUF; i++)
         if (addr == ADDR_W'(A_SEC_BASE + i)) rd_word = data_word(sec_raw[i], sec_vld[i], sec_ovr[i], fmt);
      if (addr == ADDR_W'(A_CTRL)) rd_word = DATA_W'(ctrl_q);
      if (addr == ADDR_W'(A_POS))  rd_word = DATA_W'(pos_q);
      for (int i = 0; i < NUM_LINES; i++)
         if (addr == ADDR_W'(A_MASK_BASE + i)) rd_word = DATA_W'(mask_q[i]);
      if (addr == ADDR_W'(A_STAT)) rd_word = DATA_W'(stat_word);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rdata <= '0;
      else if (rd_en) rdata <= rd_word;
   end

   a_r1_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rdata));

   a_r6_summary_tracks_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (done_valid && done_slot < SLOT_W'(NUM_SLOTS)) |=> sum_vld);

endmodule

// File: tb/adc_result_bank_bench.sv
module adc_result_bank_bench;

   localparam int NS = 19;
   localparam int ND = 4;
   localparam int NL = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_valid = 1'b0, done_valid = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
   logic [4:0]  start_slot = '0, done_slot = '0, addr = '0;
   logic [11:0] done_raw = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [3:0]  irq;

   always #4 clk = ~clk;

   adc_result_bank u_adc_result_bank (
      .clk(clk), .rst_n(rst_n),
      .start_valid(start_valid), .start_slot(start_slot),
      .done_valid(done_valid), .done_slot(done_slot), .done_raw(done_raw),
      .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .irq(irq)
   );

   int checks = 0;
   int errors = 0;

   // bench model
   logic [11:0] m_raw [NS+ND];
   bit          m_v   [NS+ND];
   bit          m_o   [NS+ND];
   bit          m_ptr [ND];
   logic [8:0]  m_ctrl;
   logic [18:0] m_pos;
   logic [18:0] m_mask [NL];
   bit   [3:0]  m_f, m_w;
   logic [31:0] exp_rd;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] fmt(input logic [11:0] r);
      if (m_ctrl[0]) return {{4{~r[11]}}, ~r[11], r[10:0]};
      return {4'h0, r};
   endfunction

   function automatic logic [31:0] mread(input int a);
      bit any_v = 0, any_o = 0;
      for (int i = 0; i < NS + ND; i++) begin any_v |= m_v[i]; any_o |= m_o[i]; end
      if (a < NS) return {14'h0, m_v[a], m_o[a], fmt(m_raw[a])};
      if (a >= 20 && a < 24) return {14'h0, m_v[a-1], m_o[a-1], fmt(m_raw[a-1])};
      if (a == 24) return {23'h0, m_ctrl};
      if (a == 25) return {13'h0, m_pos};
      if (a >= 26 && a < 30) return {13'h0, m_mask[a-26]};
      if (a == 30) return {21'h0, any_o, any_v, |m_w, m_w, m_f};
      return 32'h0;
   endfunction

   task automatic model_reset();
      for (int i = 0; i < NS + ND; i++) begin m_raw[i] = '0; m_v[i] = 0; m_o[i] = 0; end
      for (int i = 0; i < ND; i++) m_ptr[i] = 0;
      for (int i = 0; i < NL; i++) m_mask[i] = '0;
      m_ctrl = '0; m_pos = '0; m_f = '0; m_w = '0;
   endtask

   task automatic model_step(input bit sv, input int ss, input bit dv, input int ds, input int dd,
                             input bit we, input bit re, input int ad, input int wd);
      bit [3:0] hit;
      if (re) exp_rd = mread(ad);
      if (re && ad < NS) begin m_v[ad] = 0; m_o[ad] = 0; end
      if (re && ad >= 20 && ad < 24) begin m_v[ad-1] = 0; m_o[ad-1] = 0; end
      for (int l = 0; l < NL; l++)
         hit[l] = (sv && ss < NS && m_mask[l][ss] && m_pos[ss]) ||
                  (dv && ds < NS && m_mask[l][ds] && !m_pos[ds]);
      if (dv && ds < NS) begin
         int t = ds;
         if (ds < ND && m_ctrl[5+ds] && m_ptr[ds]) t = NS + ds;
         m_o[t] = m_o[t] | m_v[t];
         m_v[t] = 1;
         m_raw[t] = dd[11:0];
         if (ds < ND && m_ctrl[5+ds]) m_ptr[ds] = ~m_ptr[ds];
      end
      for (int i = 0; i < ND; i++) if (!m_ctrl[5+i]) m_ptr[i] = 0;
      begin
         bit [3:0] cf = (we && ad == 30) ? wd[3:0] : 4'h0;
         bit [3:0] cw = (we && ad == 30) ? wd[7:4] : 4'h0;
         m_w = (hit & m_f) | (m_w & ~cw);
         m_f = hit | (m_f & ~cf);
      end
      if (we && ad == 24) m_ctrl = wd[8:0];
      if (we && ad == 25) m_pos = wd[18:0];
      if (we && ad >= 26 && ad < 30) m_mask[ad-26] = wd[18:0];
   endtask

   // one clock cycle: drive at negedge, model after posedge, check at next negedge
   task automatic cyc(input bit sv, input int ss, input bit dv, input int ds, input int dd,
                      input bit we, input bit re, input int ad, input int wd, input string tag);
      start_valid = sv; start_slot = ss[4:0];
      done_valid = dv; done_slot = ds[4:0]; done_raw = dd[11:0];
      wr_en = we; rd_en = re; addr = ad[4:0]; wdata = wd;
      @(posedge clk);
      model_step(sv, ss, dv, ds, dd, we, re, ad, wd);
      @(negedge clk);
      start_valid = 0; done_valid = 0; wr_en = 0; rd_en = 0;
      if (re) chk(rdata === exp_rd, tag, rdata, exp_rd);
      chk(irq === (m_f & m_ctrl[4:1]), "R9 irq", {28'h0, irq}, {28'h0, m_f & m_ctrl[4:1]});
   endtask

   task automatic done_ev(input int s, input int d, input string tag);
      cyc(0, 0, 1, s, d, 0, 0, 0, 0, tag);
   endtask
   task automatic rd(input int a, input string tag);
      cyc(0, 0, 0, 0, 0, 0, 1, a, 0, tag);
   endtask
   task automatic wr(input int a, input int d, input string tag);
      cyc(0, 0, 0, 0, 0, 1, 0, a, d, tag);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : stim
      void'($urandom(32'd1234));
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R12 reset state
      chk(irq === 4'h0, "R12 irq after reset", {28'h0, irq}, 32'h0);
      rd(0, "R12 slot0"); rd(24, "R12 ctrl"); rd(30, "R12 status"); rd(26, "R12 mask");

      // R1 / R2 straight binary
      done_ev(5, 12'h800, "R1 load");
      rd(5, "R1 R2 straight 0x800");
      rd(31, "R1 unmapped");
      wr(24, 1, "R2 select two's complement");
      done_ev(5, 12'h800, "R2 load"); rd(5, "R2 twos 0x800");
      done_ev(5, 12'h7FF, "R2 load"); rd(5, "R2 twos 0x7FF");
      done_ev(5, 12'h000, "R2 load"); rd(5, "R2 twos 0x000");
      wr(24, 0, "R2 back to straight");

      // R3 / R4 overrun and clear
      done_ev(7, 12'h123, "R4 first"); done_ev(7, 12'h456, "R4 second");
      rd(30, "R6 summary with overrun");
      rd(7, "R4 overrun set"); rd(7, "R3 R4 cleared by read");
      done_ev(19, 12'hABC, "R3 out of range"); rd(30, "R3 out of range ignored");
      done_ev(9, 12'h111, "R4 load");
      cyc(0, 0, 1, 9, 12'h222, 0, 1, 9, 0, "R4 read and write same cycle");
      rd(9, "R4 no overrun after read-first");

      // R5 double buffering on slot 1 (control bit 6)
      wr(24, 32'h40, "R5 enable");
      done_ev(1, 12'hA01, "R5 a"); done_ev(1, 12'hA02, "R5 b");
      rd(1, "R5 primary"); rd(21, "R5 second");
      done_ev(1, 12'hA03, "R5 c"); done_ev(1, 12'hA04, "R5 d"); done_ev(1, 12'hA05, "R5 e");
      rd(1, "R5 primary overrun"); rd(21, "R5 second single");
      wr(24, 0, "R5 disable");
      done_ev(1, 12'hB01, "R5 off"); done_ev(1, 12'hB02, "R5 off");
      rd(21, "R5 second untouched"); rd(1, "R5 primary only");
      rd(30, "R6 summary clear");

      // R7 / R8 / R9 / R10 / R11 on line 2, slot 3
      wr(28, 32'h8, "R7 mask line2");
      wr(25, 32'h8, "R8 slot3 at start");
      wr(24, 32'h8, "R9 enable line2");
      done_ev(3, 12'h0, "R8 done ignored"); rd(30, "R8 no flag on done");
      done_ev(4, 12'h0, "R7 unmasked"); rd(30, "R7 unmasked slot no flag");
      cyc(1, 3, 0, 0, 0, 0, 0, 0, 0, "R8 start sets");
      rd(30, "R7 R8 flag set");
      cyc(1, 3, 0, 0, 0, 0, 0, 0, 0, "R10 second start");
      rd(30, "R10 overwrite");
      wr(30, 32'h4, "R11 clear flag"); rd(30, "R11 flag cleared, overwrite kept");
      wr(24, 0, "R9 disable line2");
      cyc(1, 3, 0, 0, 0, 0, 0, 0, 0, "R9 flag but masked irq");
      cyc(1, 3, 0, 0, 0, 1, 0, 30, 32'h44, "R11 set wins over clear");
      rd(30, "R11 flag survives, overwrite set again");
      wr(30, 32'hFF, "R11 clear all"); rd(30, "R11 all clear");

      // random phase
      wr(24, 32'h1FF, "R2 R5 R9 random config");
      wr(25, 32'h2A5A5, "R8 random positions");
      for (int l = 0; l < NL; l++) wr(26 + l, $urandom & 32'h7FFFF, "R7 random masks");
      for (int n = 0; n < 3000; n++) begin
         bit sv = ($urandom % 4) == 0;
         bit dv = ($urandom % 2) == 0;
         bit re = ($urandom % 3) == 0;
         bit we = ($urandom % 16) == 0;
         int rd_a = $urandom % 32;
         cyc(sv, $urandom % 20, dv, $urandom % 20, $urandom & 32'hFFF,
             we, re, we ? 30 : rd_a, $urandom & 32'hFF, "R1 R3 R4 R5 R6 R10 R11 random read");
         if (n == 1500) wr(24, 32'h0A3, "R2 R5 reconfigure");
      end
      for (int a = 0; a < 32; a++) rd(a, "R1 final sweep");

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule